// File: doc/BRIEF.md
# Dual-Style Host Bus Adapter

This block connects an on-chip register file to an external microprocessor bus that can come in one of two flavours. In the split-strobe flavour the host drives separate active-low read and write strobes. In the phase flavour the same two pins carry different signals: the read pin becomes a bus phase clock and the write pin becomes a read/not-write direction line. A strap input picks the flavour. It is sampled only while power-on reset is asserted, and the choice then holds until the next reset.

Both strobe pins pass through a two-flop synchronizer. Edges are detected in the core clock domain. Each completed host transfer becomes one single-cycle read-enable or write-enable pulse toward the register file, together with a registered address and write data. The register file answers a read within the same cycle. The adapter holds that answer and drives it on the host data output, with an output-enable for the pad, only while the host read is still in progress.

Top module: `host_bus_adapter`

## Requirements
- R1: With the strap low during reset (split style), a low pulse on the read pin causes exactly one register read pulse. A low pulse on the write pin causes exactly one register write pulse.
- R2: With the strap high during reset (phase style), a transfer with the direction pin low is a write. It commits on the falling edge of the phase pin, and no write pulse appears while the phase pin is still high.
- R3: In phase style, raising the phase pin while the direction pin is high performs one register read. The addressed data is then presented on the host data output while the phase pin stays high.
- R4: Strap changes after reset release have no effect. The style chosen during reset persists until the next reset.
- R5: Every committed write gives exactly one `reg_wr_en_o` pulse, one clock wide, carrying the host address and data. Every read gives one `reg_rd_en_o` pulse, one clock wide.
- R6: In split style a write commits on the rising (deasserting) edge of the write strobe. No write pulse appears while the strobe is held low.
- R7: The write pulse is high in the clock cycle that follows the third rising clock edge after the committing pin edge. This comes from two synchronizer stages plus one output register.
- R8: `host_rdata_oe_o` is high only after a read pulse, while the read is still active. While it is high, `host_rdata_o` shows the addressed register. When it is low, `host_rdata_o` is all zeros.
- R9: While reset is asserted, both enable pulses, the output-enable and the read data output are low.
- R10: In phase style, activity on the direction pin while the phase pin is low causes no register transfer.
- R11: `reg_rd_en_o` and `reg_wr_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_style_i | input | 1 | Bus style strap: 0 split strobes, 1 phase plus direction |
| host_rd_i | input | 1 | Read strobe (active low) or phase clock |
| host_wr_i | input | 1 | Write strobe (active low) or read/not-write line |
| host_addr_i | input | AW | Host register address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, zero when not driven |
| host_rdata_oe_o | output | 1 | Pad output-enable for the read data |
| reg_addr_o | output | AW | Register file address |
| reg_wdata_o | output | DW | Register file write data |
| reg_rd_en_o | output | 1 | Single-cycle register read pulse |
| reg_wr_en_o | output | 1 | Single-cycle register write pulse |
| reg_rdata_i | input | DW | Register file read data, valid in the read pulse cycle |

## Verification
A wrongly latched bus style shows up at the first transfer. Split-style writes then produce no write pulse or a spurious read, and phase-style writes commit at the wrong edge. A broken synchronizer or edge detector moves the write pulse away from its cycle three edges after the pin change, or doubles the pulse. Both are visible within a handful of clocks of the strobe. A stale read-data hold or a wrong output-enable appears on the host data pins during the same read that caused it, and a random mix of writes and reads-back against a shadow copy exposes corrupted addresses or data.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_PHASE = 1'b1
  } bus_style_e;
endpackage

// File: rtl/hba_reset_sync.sv
module hba_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/hba_sync.sv
module hba_sync #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      safe_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/hba_style_latch.sv
module hba_style_latch
  import hba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic       strap_i,
  output bus_style_e style_o
);
  bus_style_e style_q;
  bus_style_e style_d;
  logic       style_en;

  // Load only while reset is held; frozen afterwards.
  always_comb begin
    style_en = !rst_sync_n;
    style_d  = strap_i ? BUS_PHASE : BUS_SPLIT;
  end

  always_ff @(posedge clk) begin
    if (style_en) style_q <= style_d;
  end

  assign style_o = style_q;

  p_style_frozen_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable(style_q));
endmodule

// File: rtl/hba_xfer_ctrl.sv
module hba_xfer_ctrl
  import hba_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_style_e    style_i,
  input  logic          s_rd_i,
  input  logic          s_wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_active_o
);
  logic          prev_rd_q, prev_wr_q;
  logic [AW-1:0] addr_cap_q, addr_cap_d;
  logic [DW-1:0] wdata_cap_q, wdata_cap_d;
  logic          rd_en_q, wr_en_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          rd_fall, rd_rise, wr_rise;
  logic          rd_go, wr_go, rd_act, cap_en, out_en;

  always_comb begin
    rd_fall = prev_rd_q & ~s_rd_i;
    rd_rise = ~prev_rd_q & s_rd_i;
    wr_rise = ~prev_wr_q & s_wr_i;
    unique case (style_i)
      BUS_PHASE: begin
        rd_go  = rd_rise & s_wr_i;
        wr_go  = rd_fall & ~prev_wr_q;
        rd_act = s_rd_i & s_wr_i;
      end
      default: begin
        rd_go  = rd_fall;
        wr_go  = wr_rise;
        rd_act = ~s_rd_i;
      end
    endcase
    cap_en      = ~(rd_go | wr_go);
    out_en      = rd_go | wr_go;
    addr_cap_d  = addr_i;
    wdata_cap_d = wdata_i;
    addr_d      = addr_cap_q;
    wdata_d     = wdata_cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q   <= 1'b1;
      prev_wr_q   <= 1'b1;
      addr_cap_q  <= '0;
      wdata_cap_q <= '0;
      rd_en_q     <= 1'b0;
      wr_en_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      prev_rd_q <= s_rd_i;
      prev_wr_q <= s_wr_i;
      rd_en_q   <= rd_go;
      wr_en_q   <= wr_go;
      if (cap_en) begin
        addr_cap_q  <= addr_cap_d;
        wdata_cap_q <= wdata_cap_d;
      end
      if (out_en) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign rd_en_o     = rd_en_q;
  assign wr_en_o     = wr_en_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign rd_active_o = rd_act;

  // R2: a phase-style write pulse follows a phase-pin low seen after a high one
  p_phase_wr_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (style_i == BUS_PHASE && wr_en_q) |-> ($past(!s_rd_i) && $past(prev_rd_q)));
endmodule

// File: rtl/hba_read_port.sv
module hba_read_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_i,
  input  logic          rd_active_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o
);
  logic [DW-1:0] rdata_q, rdata_d;
  logic          oe_q, oe_d;

  always_comb begin
    rdata_d = reg_rdata_i;
    oe_d    = rd_active_i & (oe_q | rd_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rdata_d;
      oe_q <= oe_d;
    end
  end

  assign oe_o    = oe_q;
  assign rdata_o = oe_q ? rdata_q : '0;

  p_oe_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(rd_en_i));
  p_oe_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active_i |=> !oe_q);
endmodule

// File: rtl/host_bus_adapter.sv
module host_bus_adapter
  import hba_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_style_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_rdata_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_rd_en_o,
  output logic          reg_wr_en_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int NPINS = 2;

  logic             rst_sync_n;
  bus_style_e       style;
  logic [NPINS-1:0] pins_sync;
  logic             rd_active;

  hba_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hba_style_latch u_style (
    .clk(clk), .rst_sync_n(rst_sync_n), .strap_i(strap_style_i), .style_o(style)
  );

  hba_sync #(.WIDTH(NPINS), .RST_VAL({NPINS{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d_i({host_wr_i, host_rd_i}), .q_o(pins_sync)
  );

  hba_xfer_ctrl #(.AW(AW), .DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_sync_n), .style_i(style),
    .s_rd_i(pins_sync[0]), .s_wr_i(pins_sync[1]),
    .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .rd_en_o(reg_rd_en_o), .wr_en_o(reg_wr_en_o),
    .addr_o(reg_addr_o), .wdata_o(reg_wdata_o),
    .rd_active_o(rd_active)
  );

  hba_read_port #(.DW(DW)) u_rport (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_en_i(reg_rd_en_o), .rd_active_i(rd_active),
    .reg_rdata_i(reg_rdata_i),
    .rdata_o(host_rdata_o), .oe_o(host_rdata_oe_o)
  );

  p_en_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_rd_en_o && reg_wr_en_o));
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_en_o |=> !reg_wr_en_o);
  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rd_en_o |=> !reg_rd_en_o);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_rdata_oe_o |-> (host_rdata_o == '0));
  p_split_wr_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (style == BUS_SPLIT && reg_wr_en_o) |-> ($past(host_wr_i, 3) && !$past(host_wr_i, 4)));
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> (!reg_wr_en_o && !reg_rd_en_o && !host_rdata_oe_o));
endmodule

// File: tb/test_host_bus_adapter.sv
module test_host_bus_adapter;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strap;
  logic          pin_rd, pin_wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] host_rdata_o;
  logic          host_rdata_oe_o;
  logic [AW-1:0] reg_addr_o;
  logic [DW-1:0] reg_wdata_o;
  logic          reg_rd_en_o, reg_wr_en_o;
  logic [DW-1:0] reg_rdata_i;

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] sh [NREG];
  logic          rf_clr;

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0, last_wc = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  bit done = 0;

  always #10 clk = ~clk;

  host_bus_adapter #(.AW(AW), .DW(DW)) i_host_bus_adapter (
    .clk(clk), .rst_n(rst_n), .strap_style_i(strap),
    .host_rd_i(pin_rd), .host_wr_i(pin_wr),
    .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(host_rdata_o), .host_rdata_oe_o(host_rdata_oe_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rd_en_o(reg_rd_en_o), .reg_wr_en_o(reg_wr_en_o),
    .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = rf[reg_addr_o];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_clr) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (reg_wr_en_o) begin
      rf[reg_addr_o] <= reg_wdata_o;
    end
  end

  // Monitor samples 5 ns after the edge.
  always @(posedge clk) begin
    #5;
    if (reg_wr_en_o) begin
      wr_cnt++; last_wa = reg_addr_o; last_wd = reg_wdata_o; last_wc = cyc;
    end
    if (reg_rd_en_o) rd_cnt++;
    if (reg_rd_en_o && reg_wr_en_o) both_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s;
    pin_rd = s ? 1'b0 : 1'b1; pin_wr = 1'b1;
    rf_clr = 1'b1;
    for (int i = 0; i < NREG; i++) sh[i] = '0;
    tick(5);
    chk("R9 wr_en in reset", int'(reg_wr_en_o), 0);
    chk("R9 rd_en in reset", int'(reg_rd_en_o), 0);
    chk("R9 oe in reset", int'(host_rdata_oe_o), 0);
    chk("R9 rdata in reset", int'(host_rdata_o), 0);
    rf_clr = 1'b0;
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic split_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0, t0;
    w0 = wr_cnt;
    addr = a; wdata = d; tick(2);
    pin_wr = 1'b0; tick(6);
    chk("R6 no write while strobe low", wr_cnt, w0);
    pin_wr = 1'b1; t0 = cyc; tick(5);
    chk("R1/R5 one write pulse", wr_cnt, w0 + 1);
    chk("R7 write pulse cycle", last_wc, t0 + 3);
    chk("R5 write address", int'(last_wa), int'(a));
    chk("R5 write data", int'(last_wd), int'(d));
    sh[a] = d;
  endtask

  task automatic split_read(input logic [AW-1:0] a);
    int r0;
    r0 = rd_cnt;
    addr = a; tick(2);
    pin_rd = 1'b0; tick(6);
    chk("R1/R5 one read pulse", rd_cnt, r0 + 1);
    chk("R8 oe during read", int'(host_rdata_oe_o), 1);
    chk("R8 read data", int'(host_rdata_o), int'(sh[a]));
    pin_rd = 1'b1; tick(4);
    chk("R8 oe after read", int'(host_rdata_oe_o), 0);
    chk("R8 data zero after read", int'(host_rdata_o), 0);
  endtask

  task automatic phase_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0, r0, t0;
    w0 = wr_cnt; r0 = rd_cnt;
    pin_wr = 1'b0; addr = a; wdata = d; tick(2);
    pin_rd = 1'b1; tick(6);
    chk("R2 no write while phase high", wr_cnt, w0);
    pin_rd = 1'b0; t0 = cyc; tick(4);
    pin_wr = 1'b1; tick(1);
    chk("R2/R5 one write pulse", wr_cnt, w0 + 1);
    chk("R2 no read on write", rd_cnt, r0);
    chk("R7 phase write pulse cycle", last_wc, t0 + 3);
    chk("R5 phase write address", int'(last_wa), int'(a));
    chk("R5 phase write data", int'(last_wd), int'(d));
    sh[a] = d;
  endtask

  task automatic phase_read(input logic [AW-1:0] a);
    int r0;
    r0 = rd_cnt;
    pin_wr = 1'b1; addr = a; tick(2);
    pin_rd = 1'b1; tick(6);
    chk("R3 one read pulse", rd_cnt, r0 + 1);
    chk("R3/R8 oe during read", int'(host_rdata_oe_o), 1);
    chk("R3 read data", int'(host_rdata_o), int'(sh[a]));
    pin_rd = 1'b0; tick(4);
    chk("R8 oe after phase read", int'(host_rdata_oe_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    addr = '0; wdata = '0; rf_clr = 1'b1;

    // Split style
    do_reset(1'b0);
    split_write(4'h3, 8'hA5);
    split_read(4'h3);
    split_write(4'hF, 8'hFF);
    split_write(4'h0, 8'h00);
    split_read(4'hF);
    split_read(4'h0);

    // R4: strap flipped after reset has no effect
    strap = 1'b1; tick(3);
    split_write(4'h7, 8'h5C);
    split_read(4'h7);

    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, NREG - 1));
      if ($urandom_range(0, 1) == 1) split_write(ra, DW'($urandom));
      else split_read(ra);
    end

    // Phase style
    do_reset(1'b1);
    strap = 1'b0; tick(3);   // R4: ignored after release
    phase_write(4'h2, 8'h3C);
    phase_read(4'h2);
    phase_write(4'hE, 8'h81);
    phase_read(4'hE);

    // R10: direction activity while phase low
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      for (int k = 0; k < 4; k++) begin
        pin_wr = 1'b0; tick(4);
        pin_wr = 1'b1; tick(4);
      end
      chk("R10 no write while phase low", wr_cnt, w0);
      chk("R10 no read while phase low", rd_cnt, r0);
      chk("R10 oe idle", int'(host_rdata_oe_o), 0);
    end

    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, NREG - 1));
      if ($urandom_range(0, 1) == 1) phase_write(ra, DW'($urandom));
      else phase_read(ra);
    end

    chk("R11 enables never together", both_cnt, 0);
    tick(2);
    finish_run();
  end
endmodule